// File: doc/BRIEF.md
# Clocked Serial Shift Interface

An 8-bit synchronous serial port that sits on a 4-bit processor bus. Software fills the shift register through two nibble-wide data addresses, starts a transfer, and after eight shift clocks reads the received byte back through the same two addresses. Each shift clock moves one bit out on the serial output and takes one bit in from the serial input. The first bit on the wire is the least significant one, in both directions.

The shift clock comes from one of two sources. The first is an internal divider, with a period of 4 to 8192 system clocks chosen by a 4-bit select code that is split across two mode registers. The second is an external clock pin, which the block then only listens to. A transfer is started by a dedicated strobe or, as a side effect, by any read of mode register A, which always reads as zero. A 3-bit counter counts rising shift-clock edges. After the eighth edge, or when a running transfer is aborted, the counter is cleared, shifting stops and a sticky request flag is raised for the interrupt logic.

Top module: `ssi_shift_unit`

## Requirements
- R1: After reset, irq_flag is 0, sck_out is 1, sck_oe is 1 (select code 0, internal clock), and the data register reads back as 0.
- R2: Address 2 writes and reads bits 3:0 of the shift register, and address 3 writes and reads bits 7:4. Writes to either address while a transfer runs are ignored.
- R3: A transfer starts on a start_stb pulse or on a bus read of address 0. Reads of address 0 (mode A) and address 1 (mode B) return 0000. Starting clears the bit counter.
- R4: The select code is {mode B bit 0, mode A bits 2:0}. For codes 0 to 11 the shift clock period is 2^(code+2) clk cycles, and its high and low halves are equal. sck_out is high when idle, and its first falling edge comes half a period after the start cycle.
- R5: On each falling shift edge, so takes the current register bit 0. On each rising edge, the register shifts right and si enters at bit 7. After eight rising edges the first received bit is in bit 0.
- R6: On the eighth rising edge the transfer ends, sck_out stays high, the bit counter is 0 and irq_flag is set.
- R7: An abort_stb pulse during a transfer ends it at once, returns sck_out high and sets irq_flag. abort_stb has no effect when the block is idle.
- R8: A start request during a running transfer restarts the count from zero, so eight further shift clocks follow it.
- R9: irq_flag stays set until a write of 0 to bit 0 of address 4. A write of 1 leaves it unchanged. A set in the same cycle wins over a clear. Address 4 reads {000, irq_flag}.
- R10: Select codes 12 to 15 choose the external clock. sck_oe is 0, and the falling and rising edges of sck_in, seen through a two-stage synchronizer, drive the shifting.
- R11: While idle, a write to address 1 with bit 3 set drives so to the level of bit 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address: 0 mode A, 1 mode B, 2 data low, 3 data high, 4 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data |
| start_stb | input | 1 | Start strobe |
| abort_stb | input | 1 | Abort strobe |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Shift clock output enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| irq_flag | output | 1 | Transfer-done request flag |

## Verification
The hardest states to reach are a restart that lands in the middle of a running transfer and an abort that comes thousands of cycles into the slowest divider setting. Both need exact cycle placement against a clock the bench cannot see directly. The stimulus issues the restart part-way through a 16-cycle-period transfer. It also leaves a select-code-11 transfer running beyond its first full shift period before aborting it. A behavioural timing model compares the shift clock, the serial output and the flag on every cycle, so an edge that is off by one cycle is caught where it happens.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int NIB_W       = 4;
  localparam int DATA_W      = 2 * NIB_W;
  localparam int SEL_W       = 4;
  localparam int MAX_INT_SEL = 11;
  localparam int DIV_W       = MAX_INT_SEL + 2;
  localparam int CNT_W       = $clog2(DATA_W);
  localparam int ADDR_W      = 3;

  localparam logic [ADDR_W-1:0] A_MODE_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE_B = 3'd1;
  localparam logic [ADDR_W-1:0] A_DAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_DAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;

  // half of the shift period in clk cycles: 2^(code+1)
  function automatic logic [DIV_W-1:0] half_period(input logic [SEL_W-1:0] code);
    return {{(DIV_W-1){1'b0}}, 1'b1} << (code + 4'd1);
  endfunction

  function automatic logic uses_ext_clk(input logic [SEL_W-1:0] code);
    return code > SEL_W'(MAX_INT_SEL);
  endfunction
endpackage

// File: rtl/ssi_edge_gen.sv
module ssi_edge_gen
  import ssi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             busy,
  input  logic             start_evt,
  input  logic             abort_evt,
  input  logic             sck_in,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             sck_q,
  output logic             ext_mode
);
  logic [DIV_W-1:0] half_cnt;
  logic [2:0]       sync_q;
  logic             run, int_tick;

  assign ext_mode = uses_ext_clk(sel);
  assign run      = busy && !start_evt && !abort_evt;
  assign int_tick = run && !ext_mode && (half_cnt == half_period(sel) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sck_q    <= 1'b1;
    end else if (!run) begin
      half_cnt <= '0;
      sck_q    <= 1'b1;
    end else if (int_tick) begin
      half_cnt <= '0;
      sck_q    <= ~sck_q;
    end else if (!ext_mode) begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sck_in};
  end

  always_comb begin
    if (ext_mode) begin
      fall_evt = run && sync_q[2] && !sync_q[1];
      rise_evt = run && !sync_q[2] && sync_q[1];
    end else begin
      fall_evt = int_tick && sck_q;
      rise_evt = int_tick && !sck_q;
    end
  end
endmodule

// File: rtl/ssi_shift_core.sv
module ssi_shift_core
  import ssi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              abort_evt,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              si,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [NIB_W-1:0]  wdata,
  input  logic              flag_clr,
  input  logic              so_force,
  input  logic              so_lvl,
  output logic [DATA_W-1:0] shreg,
  output logic              so,
  output logic              busy,
  output logic              irq_flag,
  output logic              done_evt,
  output logic [CNT_W-1:0]  bit_cnt
);
  assign done_evt = rise_evt && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
    end else if (start_evt) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
    end else if (abort_evt) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
    end else if (rise_evt) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (done_evt) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (rise_evt) begin
      shreg <= {si, shreg[DATA_W-1:1]};
    end else if (!busy) begin
      if (wr_lo) shreg[NIB_W-1:0]      <= wdata;
      if (wr_hi) shreg[DATA_W-1:NIB_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                so <= 1'b1;
    else if (fall_evt)         so <= shreg[0];
    else if (so_force && !busy) so <= so_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       irq_flag <= 1'b0;
    else if (done_evt || abort_evt)   irq_flag <= 1'b1;
    else if (flag_clr)                irq_flag <= 1'b0;
  end
endmodule

// File: rtl/ssi_shift_unit.sv
module ssi_shift_unit
  import ssi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              start_stb,
  input  logic              abort_stb,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              si,
  output logic              so,
  output logic              irq_flag
);
  logic [2:0]        sel_a_q;
  logic              sel_b_q;
  logic [SEL_W-1:0]  sel;
  logic              start_evt, abort_evt, fall_evt, rise_evt, done_evt;
  logic              busy, ext_mode, flag_clr, so_force, wr_lo, wr_hi;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  assign sel = {sel_b_q, sel_a_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= '0;
      sel_b_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE_A) sel_a_q <= bus_wdata[2:0];
      if (bus_addr == A_MODE_B) sel_b_q <= bus_wdata[0];
    end
  end

  assign start_evt = start_stb || (bus_rd && bus_addr == A_MODE_A);
  assign abort_evt = abort_stb && busy && !start_evt;
  assign wr_lo     = bus_wr && bus_addr == A_DAT_LO;
  assign wr_hi     = bus_wr && bus_addr == A_DAT_HI;
  assign flag_clr  = bus_wr && bus_addr == A_FLAG && !bus_wdata[0];
  assign so_force  = bus_wr && bus_addr == A_MODE_B && bus_wdata[3];
  assign sck_oe    = !ext_mode;

  always_comb begin
    case (bus_addr)
      A_DAT_LO: bus_rdata = shreg[NIB_W-1:0];
      A_DAT_HI: bus_rdata = shreg[DATA_W-1:NIB_W];
      A_FLAG:   bus_rdata = {{(NIB_W-1){1'b0}}, irq_flag};
      default:  bus_rdata = '0;
    endcase
  end

  ssi_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .sel(sel), .busy(busy),
    .start_evt(start_evt), .abort_evt(abort_evt), .sck_in(sck_in),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .sck_q(sck_out), .ext_mode(ext_mode)
  );

  ssi_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .abort_evt(abort_evt),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .si(si),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .flag_clr(flag_clr),
    .so_force(so_force), .so_lvl(bus_wdata[1]), .shreg(shreg), .so(so),
    .busy(busy), .irq_flag(irq_flag), .done_evt(done_evt), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/ssi_shift_chk.sv
module ssi_shift_chk
  import ssi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start_evt,
  input logic             abort_evt,
  input logic             done_evt,
  input logic             rise_evt,
  input logic             flag_clr,
  input logic             irq_flag,
  input logic             sck_out,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_start_clears_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (bit_cnt == '0 && busy));

  assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq_flag && !busy && sck_out));

  assert_idle_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bit_cnt == '0 && sck_out));

  assert_abort_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (irq_flag && !busy));

  assert_rise_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> busy);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
endmodule

bind ssi_shift_unit ssi_shift_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_evt(start_evt),
  .abort_evt(abort_evt), .done_evt(done_evt), .rise_evt(rise_evt),
  .flag_clr(flag_clr), .irq_flag(irq_flag), .sck_out(sck_out), .bit_cnt(bit_cnt)
);

// File: tb/ssi_shift_unit_tb.sv
module ssi_shift_unit_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0, start_stb = 0, abort_stb = 0, sck_in = 1, si = 0;
  logic [3:0] wdata = 0;
  wire [3:0] rdata;
  wire sck_out, sck_oe, so, irq_flag;

  always #4 clk = ~clk;

  ssi_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .start_stb(start_stb), .abort_stb(abort_stb),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so), .irq_flag(irq_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0, cmp_on = 0, si_rand = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_sel = 0, m_el = 0, m_bits = 0, m_per = 4;
  bit m_busy = 0, m_flag = 0, m_sck = 1, m_so = 0, m_so_known = 0, set_f = 0;
  logic [7:0] m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_busy = 0; m_flag = 0; m_sck = 1; m_so_known = 0; m_data = 0;
    end else begin
      set_f = 0;
      if (wr && !m_busy && addr == 2) m_data[3:0] = wdata;
      if (wr && !m_busy && addr == 3) m_data[7:4] = wdata;
      if (wr && !m_busy && addr == 1 && wdata[3]) begin m_so = wdata[1]; m_so_known = 1; end
      if (start_stb || (rd && addr == 0)) begin
        m_busy = 1; m_el = 0; m_bits = 0; m_sck = 1; m_per = 1 << (m_sel + 2);
      end else if (abort_stb && m_busy) begin
        m_busy = 0; m_sck = 1; set_f = 1;
      end else if (m_busy && m_sel <= 11) begin
        m_el++;
        if (m_el % m_per == m_per / 2) begin
          m_sck = 0; m_so = m_data[0]; m_so_known = 1;
        end else if (m_el % m_per == 0) begin
          m_sck = 1; m_data = {si, m_data[7:1]}; m_bits++;
          if (m_bits == 8) begin m_busy = 0; set_f = 1; end
        end
      end
      if (set_f) m_flag = 1;
      else if (wr && addr == 4 && !wdata[0]) m_flag = 0;
      if (wr && addr == 0) m_sel = (m_sel & 8) | int'(wdata[2:0]);
      if (wr && addr == 1) m_sel = (m_sel & 7) | (int'(wdata[0]) << 3);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(sck_out === m_sck, "R4 sck_out", sck_out, m_sck);
      chk(irq_flag === m_flag, "R6 irq_flag", irq_flag, m_flag);
      if (m_so_known) chk(so === m_so, "R5 so", so, m_so);
    end
    if (si_rand) si <= 1'($urandom % 2);
  end

  task automatic wr_reg(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_stb = 1;
    @(negedge clk); start_stb = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] lo, hi;
    logic [7:0] tx, rx;
    wait_cyc(5);
    rst_n = 1;
    @(negedge clk);
    chk(irq_flag === 0, "R1 irq after reset", irq_flag, 0);
    chk(sck_out === 1, "R1 sck_out after reset", sck_out, 1);
    chk(sck_oe === 1, "R1 sck_oe after reset", sck_oe, 1);
    rd_reg(3'd2, lo);
    chk(lo === 0, "R1 data after reset", lo, 0);
    cmp_on = 1;

    // R2 nibble access
    wr_reg(3'd2, 4'h5); wr_reg(3'd3, 4'hA);
    rd_reg(3'd2, lo); rd_reg(3'd3, hi);
    chk({hi, lo} === 8'hA5, "R2 nibble readback", {hi, lo}, 8'hA5);

    // R4 R5 R6 transfer at code 0 by strobe
    si_rand = 1;
    pulse_start();
    wait_cyc(40);
    chk(irq_flag === 1, "R6 flag after 8 clocks", irq_flag, 1);
    rd_reg(3'd2, lo); rd_reg(3'd3, hi);
    chk({hi, lo} === m_data, "R5 received byte", {hi, lo}, m_data);

    // R9 flag clear rules
    wr_reg(3'd4, 4'h1);
    rd_reg(3'd4, lo);
    chk(lo === 4'h1, "R9 write 1 keeps flag", lo, 1);
    wr_reg(3'd4, 4'h0);
    chk(irq_flag === 0, "R9 write 0 clears flag", irq_flag, 0);

    // R3 start by mode read, R2 ignored write, R8 restart, code 2
    wr_reg(3'd0, 4'h2);
    wr_reg(3'd2, 4'hC); wr_reg(3'd3, 4'h3);
    rd_reg(3'd0, lo);
    chk(lo === 0, "R3 mode A reads zero", lo, 0);
    rd_reg(3'd1, hi);
    chk(hi === 0, "R3 mode B reads zero", hi, 0);
    chk(sck_out === 1 && m_busy, "R3 transfer started by read", sck_out, 1);
    wait_cyc(18);
    wr_reg(3'd2, 4'hF);
    rd_reg(3'd2, lo);
    chk(lo === m_data[3:0], "R2 write ignored while busy", lo, m_data[3:0]);
    pulse_start();
    wait_cyc(110);
    chk(irq_flag === 0, "R8 restart extends transfer", irq_flag, 0);
    wait_cyc(30);
    chk(irq_flag === 1, "R8 restarted transfer completes", irq_flag, 1);
    wr_reg(3'd4, 4'h0);

    // R7 abort at code 11
    wr_reg(3'd0, 4'h3); wr_reg(3'd1, 4'h1);
    pulse_start();
    wait_cyc(10000);
    @(negedge clk); abort_stb = 1;
    @(negedge clk); abort_stb = 0;
    chk(irq_flag === 1, "R7 abort sets flag", irq_flag, 1);
    chk(sck_out === 1, "R7 abort returns sck high", sck_out, 1);
    wait_cyc(50);
    chk(sck_out === 1, "R7 stays idle after abort", sck_out, 1);
    wr_reg(3'd4, 4'h0);
    @(negedge clk); abort_stb = 1;
    @(negedge clk); abort_stb = 0;
    chk(irq_flag === 0, "R7 idle abort ignored", irq_flag, 0);

    // R11 idle level force
    wr_reg(3'd0, 4'h0);
    wr_reg(3'd1, 4'h8);
    chk(so === 0, "R11 force low", so, 0);
    wr_reg(3'd1, 4'hA);
    chk(so === 1, "R11 force high", so, 1);

    // R10 external clock, code 12
    cmp_on = 0; si_rand = 0;
    wr_reg(3'd0, 4'h4); wr_reg(3'd1, 4'h1);
    chk(sck_oe === 0, "R10 sck_oe off in external mode", sck_oe, 0);
    tx = 8'h96; rx = 8'h5B;
    wr_reg(3'd2, tx[3:0]); wr_reg(3'd3, tx[7:4]);
    pulse_start();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_in = 0; si = rx[i];
      wait_cyc(6);
      chk(so === tx[i], "R10 external so bit", so, tx[i]);
      sck_in = 1;
      wait_cyc(6);
    end
    chk(irq_flag === 1, "R10 external done flag", irq_flag, 1);
    rd_reg(3'd2, lo); rd_reg(3'd3, hi);
    chk({hi, lo} === rx, "R10 external received byte", {hi, lo}, rx);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule